// File: doc/BRIEF.md
# Immediate Command Mailbox

This block passes single command bytes in both directions between a host bus and an embedded CPU bus. It has two one-byte mailboxes. The inbound mailbox is loaded by the host and drained by the CPU. The outbound mailbox is loaded by the CPU and drained by the host. Each mailbox has one full/empty state, and each side sees that state in its own status byte with opposite polarity. The CPU status byte shows "empty" as a one. The host status byte shows "full" as a one.

Traffic on either mailbox raises sticky events. The host loading the inbound mailbox and the host draining the outbound mailbox each set a pending flag for the CPU. The CPU interrupt line is the OR of the pending flags that are enabled. When the inbound mailbox goes from full to empty, a separate sticky request flag is set. If it is enabled, that flag drives a request-for-service line to the host, which tells the host it may send the next command. Both buses share one clock. Both use single-cycle read and write strobes with 8-bit data, and read data is registered.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, both mailboxes are empty. The CPU status byte (CPU address 1) reads 0x44, the host status byte (host address 1) reads 0x00, the enable register reads 0, both read data outputs are 0, and `cpuIrq` and `hostRfs` are low.
- R2: A host write at host address 0 loads the inbound byte. It sets bit 2 of the host status byte and clears bit 2 of the CPU status byte.
- R3: A CPU read at CPU address 0 returns the inbound byte. When the mailbox is full, the read sets bit 2 of the CPU status byte and clears bit 2 of the host status byte.
- R4: A CPU write at CPU address 0 loads the outbound byte. It sets bit 6 of the host status byte and clears bit 6 of the CPU status byte.
- R5: A host read at host address 0 returns the outbound byte. It sets bit 6 of the CPU status byte and clears bit 6 of the host status byte.
- R6: The pending register at CPU address 3 has two flags. Bit 0 is set by every host write at host address 0. Bit 1 is set by every host read at host address 0. A CPU write of one to a bit clears that bit, and a write of zero leaves it unchanged. If a set and a clear of the same bit fall in one cycle, the set wins.
- R7: The enable register at CPU address 2 can be read and written, with bits [2:0]. `cpuIrq` is high exactly when a pending bit is set and the enable bit at the same position is set.
- R8: A full-to-empty transition of the inbound mailbox sets a sticky request flag. A host read at host address 1 clears it, but a new transition in the same cycle wins over the clear. `hostRfs` equals this flag ANDed with enable bit 2.
- R9: A write to a mailbox that is already full replaces the byte, and the mailbox stays full.
- R10: If both sides access in the same cycle, the host access takes effect first. A host write combined with a CPU read of the inbound mailbox returns the new byte, leaves the mailbox empty and sets the request flag. A host read combined with a CPU write of the outbound mailbox returns the old byte and leaves the mailbox full.
- R11: Read data appears on the clock edge that samples the read strobe, and it holds until the next read on the same side. Reads of status, enable and pending registers return the values from before that edge.
- R12: A CPU read of the empty inbound mailbox changes no status and sets no request flag. A host write at host address 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 1 | Host register select: 0 mailbox byte, 1 host status |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Registered host read data |
| hostRfs | output | 1 | Request-for-service line to the host |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| cpuAddr | input | 2 | CPU register select: 0 mailbox, 1 status, 2 enables, 3 pending |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Registered CPU read data |
| cpuIrq | output | 1 | Interrupt line to the CPU |

## Verification
Directed sequences first walk each mailbox through fill and drain on its own. They then load a mailbox that is already full, which separates overwrite from a blocked write. Next they put host and CPU accesses to the same mailbox in one cycle, which exposes the order of the two sides. They also set and clear one pending bit in one cycle, and drain the inbound mailbox while the host reads its status, which shows which side wins each race. A long run of random accesses on both sides, mixed with random enable and clear writes, then checks every output each cycle against a bench model of the rules. Many interleavings of fills, drains and toggled enables are covered this way.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  localparam int DATA_W     = 8;
  localparam int CPU_ADDR_W = 2;
  localparam int IN_BIT     = 2;   // status bit position for the inbound mailbox
  localparam int OUT_BIT    = 6;   // status bit position for the outbound mailbox
  localparam int NUM_SRC    = 2;   // pending interrupt sources
  localparam int EN_W       = NUM_SRC + 1;
  localparam int RFS_EN_BIT = NUM_SRC;

  typedef enum logic [CPU_ADDR_W-1:0] {
    CPU_CMD   = 2'd0,
    CPU_STAT  = 2'd1,
    CPU_EN    = 2'd2,
    CPU_FLAGS = 2'd3
  } cpuReg_e;

  typedef struct packed {
    logic    hostLoadIn;   // host writes inbound byte
    logic    cpuLoadOut;   // cpu writes outbound byte
    logic    cpuRdStb;     // capture cpu read data
    cpuReg_e cpuSel;       // cpu read source
    logic    hostRdStb;    // capture host read data
    logic    hostSelStat;  // host read source: status instead of byte
  } dpCtrl_t;
endpackage

// File: rtl/cmd_mailbox_ctrl.sv
module cmd_mailbox_ctrl
  import cmd_mailbox_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic                  hostAddr,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [EN_W-1:0]       cpuWrLow,
  output dpCtrl_t               dpCtrl,
  output logic [DATA_W-1:0]     slaveStat,
  output logic [DATA_W-1:0]     hostStat,
  output logic [EN_W-1:0]       ienReg,
  output logic [NUM_SRC-1:0]    pendReg,
  output logic                  cpuIrq,
  output logic                  hostRfs
);
  cpuReg_e cpuSel;
  logic hostFillIn, hostDrainOut, hostStatRd;
  logic cpuDrainIn, cpuFillOut, cpuEnWr, cpuClrWr;
  logic inFull, outFull, inAfterHost, inGoesEmpty, rfsFlag;
  logic [NUM_SRC-1:0] srcEvent;

  assign cpuSel       = cpuReg_e'(cpuAddr);
  assign hostFillIn   = hostWr && !hostAddr;
  assign hostDrainOut = hostRd && !hostAddr;
  assign hostStatRd   = hostRd && hostAddr;
  assign cpuDrainIn   = cpuRd && (cpuSel == CPU_CMD);
  assign cpuFillOut   = cpuWr && (cpuSel == CPU_CMD);
  assign cpuEnWr      = cpuWr && (cpuSel == CPU_EN);
  assign cpuClrWr     = cpuWr && (cpuSel == CPU_FLAGS);

  // host side acts first, then the cpu side sees the result
  assign inAfterHost = inFull || hostFillIn;
  assign inGoesEmpty = cpuDrainIn && inAfterHost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
      ienReg  <= '0;
      rfsFlag <= 1'b0;
    end else begin
      inFull <= cpuDrainIn ? 1'b0 : inAfterHost;
      if (cpuFillOut)        outFull <= 1'b1;
      else if (hostDrainOut) outFull <= 1'b0;
      if (cpuEnWr) ienReg <= cpuWrLow;
      if (inGoesEmpty)     rfsFlag <= 1'b1;
      else if (hostStatRd) rfsFlag <= 1'b0;
    end
  end

  assign srcEvent = {hostDrainOut, hostFillIn};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)                          pendReg[i] <= 1'b0;
      else if (srcEvent[i])               pendReg[i] <= 1'b1;
      else if (cpuClrWr && cpuWrLow[i])   pendReg[i] <= 1'b0;
    end
  end

  always_comb begin
    slaveStat          = '0;
    hostStat           = '0;
    slaveStat[IN_BIT]  = !inFull;
    slaveStat[OUT_BIT] = !outFull;
    hostStat[IN_BIT]   = inFull;
    hostStat[OUT_BIT]  = outFull;
  end

  assign cpuIrq  = |(pendReg & ienReg[NUM_SRC-1:0]);
  assign hostRfs = rfsFlag && ienReg[RFS_EN_BIT];

  always_comb begin
    dpCtrl             = '0;
    dpCtrl.hostLoadIn  = hostFillIn;
    dpCtrl.cpuLoadOut  = cpuFillOut;
    dpCtrl.cpuRdStb    = cpuRd;
    dpCtrl.cpuSel      = cpuSel;
    dpCtrl.hostRdStb   = hostRd;
    dpCtrl.hostSelStat = hostAddr;
  end
endmodule

// File: rtl/cmd_mailbox_dp.sv
module cmd_mailbox_dp
  import cmd_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] slaveStat,
  input  logic [DATA_W-1:0] hostStat,
  input  logic [EN_W-1:0]   ienReg,
  input  logic [NUM_SRC-1:0] pendReg,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] hostRdData
);
  logic [DATA_W-1:0] inReg, outReg, cpuRdNext, hostRdNext;

  // a same-cycle host load is seen by the cpu read (host first)
  always_comb begin
    unique case (dpCtrl.cpuSel)
      CPU_CMD:   cpuRdNext = dpCtrl.hostLoadIn ? hostWrData : inReg;
      CPU_STAT:  cpuRdNext = slaveStat;
      CPU_EN:    cpuRdNext = DATA_W'(ienReg);
      default:   cpuRdNext = DATA_W'(pendReg);
    endcase
  end

  assign hostRdNext = dpCtrl.hostSelStat ? hostStat : outReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg      <= '0;
      outReg     <= '0;
      cpuRdData  <= '0;
      hostRdData <= '0;
    end else begin
      if (dpCtrl.hostLoadIn) inReg      <= hostWrData;
      if (dpCtrl.cpuLoadOut) outReg     <= cpuWrData;
      if (dpCtrl.cpuRdStb)   cpuRdData  <= cpuRdNext;
      if (dpCtrl.hostRdStb)  hostRdData <= hostRdNext;
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic                  hostAddr,
  input  logic [DATA_W-1:0]     hostWrData,
  output logic [DATA_W-1:0]     hostRdData,
  output logic                  hostRfs,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]     cpuWrData,
  output logic [DATA_W-1:0]     cpuRdData,
  output logic                  cpuIrq
);
  dpCtrl_t            dpCtrl;
  logic [DATA_W-1:0]  slaveStat, hostStat;
  logic [EN_W-1:0]    ienReg;
  logic [NUM_SRC-1:0] pendReg;

  cmd_mailbox_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .cpuWr     (cpuWr),
    .cpuRd     (cpuRd),
    .cpuAddr   (cpuAddr),
    .cpuWrLow  (cpuWrData[EN_W-1:0]),
    .dpCtrl    (dpCtrl),
    .slaveStat (slaveStat),
    .hostStat  (hostStat),
    .ienReg    (ienReg),
    .pendReg   (pendReg),
    .cpuIrq    (cpuIrq),
    .hostRfs   (hostRfs)
  );

  cmd_mailbox_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .hostWrData (hostWrData),
    .cpuWrData  (cpuWrData),
    .slaveStat  (slaveStat),
    .hostStat   (hostStat),
    .ienReg     (ienReg),
    .pendReg    (pendReg),
    .cpuRdData  (cpuRdData),
    .hostRdData (hostRdData)
  );
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
  import cmd_mailbox_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  hostWr,
  input logic                  hostRd,
  input logic                  hostAddr,
  input logic                  cpuWr,
  input logic                  cpuRd,
  input logic [CPU_ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0]     cpuRdData,
  input logic                  hostRfs,
  input logic                  cpuIrq,
  input logic [DATA_W-1:0]     slaveStat,
  input logic [DATA_W-1:0]     hostStat,
  input logic [EN_W-1:0]       ienReg
);
  logic cpuCmdRd, cpuCmdWr;
  assign cpuCmdRd = cpuRd && (cpuAddr == CPU_CMD);
  assign cpuCmdWr = cpuWr && (cpuAddr == CPU_CMD);

  AST_IN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr && !cpuCmdRd) |=> (hostStat[IN_BIT] && !slaveStat[IN_BIT])); // R2

  AST_IN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    cpuCmdRd |=> (slaveStat[IN_BIT] && !hostStat[IN_BIT])); // R3

  AST_OUT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    cpuCmdWr |=> (hostStat[OUT_BIT] && !slaveStat[OUT_BIT])); // R4

  AST_OUT_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostAddr && !cpuCmdWr) |=> (slaveStat[OUT_BIT] && !hostStat[OUT_BIT])); // R5

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (ienReg[NUM_SRC-1:0] != '0)); // R7

  AST_RFS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr && !cpuCmdRd) |=> !hostRfs); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> $stable(cpuRdData)); // R11
endmodule

bind cmd_mailbox cmd_mailbox_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostAddr  (hostAddr),
  .cpuWr     (cpuWr),
  .cpuRd     (cpuRd),
  .cpuAddr   (cpuAddr),
  .cpuRdData (cpuRdData),
  .hostRfs   (hostRfs),
  .cpuIrq    (cpuIrq),
  .slaveStat (slaveStat),
  .hostStat  (hostStat),
  .ienReg    (ienReg)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;
  localparam time CLK_PERIOD = 20ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0, hostAddr = 1'b0;
  logic [7:0] hostWrData = '0, hostRdData;
  logic       hostRfs;
  logic       cpuWr = 1'b0, cpuRd = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0, cpuRdData;
  logic       cpuIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] mIn = '0, mOut = '0, eCpuRd = '0, eHostRd = '0;
  logic       mInFull = 0, mOutFull = 0, mRfs = 0;
  logic [1:0] mPend = '0;
  logic [2:0] mIen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_mailbox i_cmd_mailbox (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostRfs(hostRfs),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuIrq(cpuIrq)
  );

  function automatic logic [7:0] cpuStatByte(input logic inF, input logic outF);
    return {1'b0, !outF, 3'b000, !inF, 2'b00};
  endfunction

  function automatic logic [7:0] hostStatByte(input logic inF, input logic outF);
    return {1'b0, outF, 3'b000, inF, 2'b00};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Applies the rules of the requirements to the strobes driven this cycle.
  task automatic modelStep();
    logic fillIn, drainOut, statRd, cmdRd, cmdWr, enWr, clrWr;
    fillIn   = hostWr && !hostAddr;
    drainOut = hostRd && !hostAddr;
    statRd   = hostRd && hostAddr;
    cmdRd    = cpuRd && cpuAddr == 2'd0;
    cmdWr    = cpuWr && cpuAddr == 2'd0;
    enWr     = cpuWr && cpuAddr == 2'd2;
    clrWr    = cpuWr && cpuAddr == 2'd3;
    // R11: register reads see the values from before the edge
    if (hostRd) eHostRd = hostAddr ? hostStatByte(mInFull, mOutFull) : mOut;
    if (cpuRd && cpuAddr == 2'd1) eCpuRd = cpuStatByte(mInFull, mOutFull);
    if (cpuRd && cpuAddr == 2'd2) eCpuRd = {5'b0, mIen};
    if (cpuRd && cpuAddr == 2'd3) eCpuRd = {6'b0, mPend};
    // R6: clears first so that sets win
    if (clrWr) mPend = mPend & ~cpuWrData[1:0];
    if (statRd) mRfs = 1'b0;
    // R10: host side first
    if (fillIn) begin mIn = hostWrData; mInFull = 1'b1; mPend[0] = 1'b1; end
    if (drainOut) begin mOutFull = 1'b0; mPend[1] = 1'b1; end
    if (cmdRd) begin
      eCpuRd = mIn;
      if (mInFull) mRfs = 1'b1;
      mInFull = 1'b0;
    end
    if (cmdWr) begin mOut = cpuWrData; mOutFull = 1'b1; end
    if (enWr) mIen = cpuWrData[2:0];
  endtask

  task automatic cyc(input logic hw, input logic hr, input logic ha, input logic [7:0] hwd,
                     input logic cw, input logic cr, input logic [1:0] ca, input logic [7:0] cwd,
                     input string tag);
    @(negedge clk);
    hostWr = hw; hostRd = hr; hostAddr = ha; hostWrData = hwd;
    cpuWr = cw; cpuRd = cr; cpuAddr = ca; cpuWrData = cwd;
    modelStep();
    @(posedge clk);
    #1;
    check(cpuRdData, eCpuRd, {tag, " cpuRdData"});
    check(hostRdData, eHostRd, {tag, " hostRdData"});
    check({7'b0, cpuIrq}, {7'b0, |(mPend & mIen[1:0])}, {tag, " cpuIrq"});
    check({7'b0, hostRfs}, {7'b0, mRfs & mIen[2]}, {tag, " hostRfs"});
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 0, 0, 2'd0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state of outputs
    check(cpuRdData, 8'h00, "R1 cpuRdData");
    check(hostRdData, 8'h00, "R1 hostRdData");
    check({7'b0, cpuIrq}, 8'h00, "R1 cpuIrq");
    check({7'b0, hostRfs}, 8'h00, "R1 hostRfs");
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd1, 8'h00, "R1");
    check(cpuRdData, 8'h44, "R1 cpu status");
    cyc(0, 1, 1, 8'h00, 0, 1, 2'd2, 8'h00, "R1");
    check(hostRdData, 8'h00, "R1 host status");
    check(cpuRdData, 8'h00, "R1 enables");
    // R7 enable everything
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd2, 8'h07, "R7");
    // R2 host fills inbound
    cyc(1, 0, 0, 8'hA5, 0, 0, 2'd0, 8'h00, "R2");
    check({7'b0, cpuIrq}, 8'h01, "R2 irq");
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd1, 8'h00, "R2");
    check(cpuRdData, 8'h40, "R2 cpu status");
    // R9 overwrite, R3 drain, R8 request
    cyc(1, 0, 0, 8'h3C, 0, 0, 2'd0, 8'h00, "R9");
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd0, 8'h00, "R3");
    check(cpuRdData, 8'h3C, "R9 overwritten byte");
    check({7'b0, hostRfs}, 8'h01, "R8 request raised");
    cyc(0, 1, 1, 8'h00, 0, 0, 2'd0, 8'h00, "R8");
    check(hostRdData, 8'h00, "R3 host status");
    check({7'b0, hostRfs}, 8'h00, "R8 request cleared");
    // R12 read of empty inbound
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd0, 8'h00, "R12");
    check({7'b0, hostRfs}, 8'h00, "R12 no request");
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd1, 8'h00, "R12");
    check(cpuRdData, 8'h44, "R12 status unchanged");
    // R6 clear pending bit 0
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd3, 8'h01, "R6");
    check({7'b0, cpuIrq}, 8'h00, "R6 cleared");
    // R4 outbound fill, R9 overwrite, R5 drain
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h77, "R4");
    cyc(0, 1, 1, 8'h00, 0, 1, 2'd1, 8'h00, "R4");
    check(hostRdData, 8'h40, "R4 host status");
    check(cpuRdData, 8'h04, "R4 cpu status");
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h88, "R9");
    cyc(0, 1, 0, 8'h00, 0, 0, 2'd0, 8'h00, "R5");
    check(hostRdData, 8'h88, "R5 outbound byte");
    check({7'b0, cpuIrq}, 8'h01, "R6 outbound pending");
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd2, 8'h05, "R7");
    check({7'b0, cpuIrq}, 8'h00, "R7 masked");
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd2, 8'h07, "R7");
    check({7'b0, cpuIrq}, 8'h01, "R7 unmasked");
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd3, 8'h00, "R6");
    check({7'b0, cpuIrq}, 8'h01, "R6 zero write ignored");
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd3, 8'h03, "R6");
    // R10 same-cycle inbound
    cyc(1, 0, 0, 8'h5A, 0, 1, 2'd0, 8'h00, "R10");
    check(cpuRdData, 8'h5A, "R10 bypassed byte");
    check({7'b0, hostRfs}, 8'h01, "R10 request");
    cyc(0, 1, 1, 8'h00, 0, 0, 2'd0, 8'h00, "R10");
    check(hostRdData, 8'h00, "R10 inbound empty");
    // R10 same-cycle outbound
    cyc(0, 0, 0, 8'h00, 1, 0, 2'd0, 8'h22, "R10");
    cyc(0, 1, 0, 8'h00, 1, 0, 2'd0, 8'h33, "R10");
    check(hostRdData, 8'h22, "R10 old byte");
    cyc(0, 1, 1, 8'h00, 0, 0, 2'd0, 8'h00, "R10");
    check(hostRdData, 8'h40, "R10 outbound full");
    cyc(0, 1, 0, 8'h00, 0, 0, 2'd0, 8'h00, "R10");
    check(hostRdData, 8'h33, "R10 new byte");
    // R6 set wins over clear
    cyc(1, 0, 0, 8'h99, 1, 0, 2'd3, 8'h03, "R6");
    cyc(0, 0, 0, 8'h00, 0, 1, 2'd3, 8'h00, "R6");
    check(cpuRdData, 8'h01, "R6 set wins");
    // R12 host write to status address
    cyc(1, 0, 1, 8'hFF, 0, 0, 2'd0, 8'h00, "R12");
    cyc(0, 1, 1, 8'h00, 0, 1, 2'd0, 8'h00, "R12");
    check(hostRdData, 8'h04, "R12 host status kept");
    check(cpuRdData, 8'h99, "R12 byte kept");
    // R8 drain races host status read: set wins
    cyc(1, 0, 0, 8'h12, 0, 0, 2'd0, 8'h00, "R8");
    cyc(0, 1, 1, 8'h00, 0, 1, 2'd0, 8'h00, "R8");
    check({7'b0, hostRfs}, 8'h01, "R8 set wins");
    // random traffic checked against the model (R11 and all rules)
    for (int n = 0; n < 4000; n++) begin
      logic hw, hr, ha, cw, cr;
      logic [1:0] ca;
      int op;
      hw = ($urandom % 3) == 0;
      hr = ($urandom % 3) == 0;
      ha = ($urandom % 4) == 0;
      op = $urandom % 5;
      cw = (op == 1);
      cr = (op == 2) || (op == 3);
      ca = (op == 3) ? 2'd0 : 2'($urandom % 4);
      cyc(hw, hr, ha, 8'($urandom), cw, cr, ca, 8'($urandom), "R11 random");
    end
    idle("R11");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule